// File: doc/BRIEF.md
# Program Sequencer with Skip Logic

This block decides, cycle by cycle, which program word a small 4-bit controller fetches next and whether the word in hand takes effect. The 10-bit program counter is split into a 4-bit page and a 6-bit offset within the page. Short branches stay on the current page, and long branches reach any of the 1024 words. A two-entry hardware return stack holds subroutine return addresses. A one-bit skip flag turns the following instruction into a no-operation.

An instruction decoder upstream presents a class code for the word at `fetch_addr`, together with the branch target and the skip condition from the ALU. The sequencer returns the next fetch address and `exec_en`. When `exec_en` is low, the rest of the core must discard the effects of that cycle. The sequencer also discards, in hardware, an immediate load that directly repeats the same kind of load, and a page-bit set or clear that directly follows another one. Program code can therefore chain such loads and let only the first of them act.

Top module: `pseq_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `fetch_addr` is 000h, `second_word` is 0 and `exec_en` is 1.
- R2: An ordinary instruction, or any squashed one, moves `fetch_addr` to its own address plus one, with wrap from 3FFh to 000h (class code 0 is ordinary).
- R3: An executed short jump (code 1) or short call (code 2) keeps the page bits [9:6] of its own address and takes bits [5:0] from `target`.
- R4: A long jump (code 3), long call (code 4) and compare-immediate (code 9) each occupy two cycles. In the second cycle `second_word` is 1 and `op_class` is ignored. A long branch loads all 10 bits of `target` in that second cycle.
- R5: An executed call pushes the address that follows the whole instruction onto level 1 and moves level 1 to level 2. After three nested calls, the oldest return address is lost.
- R6: An executed return (code 5) jumps to level 1 and copies level 2 into level 1. Level 2 is left unchanged, so further returns keep producing the same address.
- R7: `skip_set` in an executed one-word cycle, or in the second cycle of an executed compare-immediate, squashes the next instruction (`exec_en` low). The flag is then cleared, so the instruction after that one executes.
- R8: A squashed instruction has no branch, stack or skip effect. When a two-word instruction is squashed, both of its cycles are squashed.
- R9: An immediate load of A (code 6) whose last executed predecessor was also an immediate load of A is squashed. A chain of such loads is squashed after its first member.
- R10: The same rule applies to immediate loads of L (code 7). A load of L that follows a load of A is not affected by it.
- R11: A set or clear of the page bit H (code 8) that directly follows an executed set or clear of H is squashed.
- R12: A squashed instruction never counts as the predecessor for R9 to R11. An immediate load squashed by the skip flag is therefore followed by a load of the same kind that executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_class | input | 4 | Decoded class of the word at `fetch_addr` |
| target | input | 10 | Branch target (second word for long forms) |
| skip_set | input | 1 | ALU condition that sets the skip flag |
| fetch_addr | output | 10 | Address of the word being fetched this cycle |
| exec_en | output | 1 | 1 when this cycle's word takes effect, 0 when squashed |
| second_word | output | 1 | 1 in the second cycle of a two-word instruction |

## Verification
The hardest case to reach is a two-word instruction that has been squashed by a compare-immediate. In that case the skip flag is raised in a second-word cycle, and it must then suppress both cycles of a long jump whose target would otherwise move the counter off the page. A small program in a bench-modelled ROM builds this chain, followed by one compare that fails. The stack underflow case is reached with three nested calls of mixed short and long form. Three returns follow, the last one returning to itself, so a dropped entry would show up as a fetch from an address that must never appear.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  // instruction class codes presented by the decoder
  localparam logic [3:0] OPC_OTHER = 4'd0;
  localparam logic [3:0] OPC_JMPS  = 4'd1;
  localparam logic [3:0] OPC_CALS  = 4'd2;
  localparam logic [3:0] OPC_JMPL  = 4'd3;
  localparam logic [3:0] OPC_CALL  = 4'd4;
  localparam logic [3:0] OPC_RET   = 4'd5;
  localparam logic [3:0] OPC_LDAI  = 4'd6;
  localparam logic [3:0] OPC_LDLI  = 4'd7;
  localparam logic [3:0] OPC_HBIT  = 4'd8;
  localparam logic [3:0] OPC_CMPI  = 4'd9;

  // kind of the last executed instruction, for the repeat rule
  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_A    = 2'd1,
    LK_L    = 2'd2,
    LK_H    = 2'd3
  } lastk_e;

  function automatic logic is_two_word(input logic [3:0] op);
    return (op == OPC_JMPL) || (op == OPC_CALL) || (op == OPC_CMPI);
  endfunction

  function automatic lastk_e load_kind(input logic [3:0] op);
    case (op)
      OPC_LDAI: return LK_A;
      OPC_LDLI: return LK_L;
      OPC_HBIT: return LK_H;
      default:  return LK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pseq_stack.sv
module pseq_stack #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top
);

  logic [W-1:0] lvl_q [DEPTH];
  logic [W-1:0] lvl_d [DEPTH];
  logic         lvl_en;

  assign lvl_en = push | pop;
  assign top    = lvl_q[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    // push shifts toward the deep end; pop shifts toward level 1,
    // the deepest entry keeps its value
    if (i == 0) begin : g_first
      if (DEPTH > 1) begin : g_multi
        always_comb begin
          if (push) lvl_d[i] = push_val;
          else      lvl_d[i] = lvl_q[i+1];
        end
      end else begin : g_single
        always_comb begin
          if (push) lvl_d[i] = push_val;
          else      lvl_d[i] = lvl_q[i];
        end
      end
    end else if (i == DEPTH - 1) begin : g_last
      always_comb begin
        if (push) lvl_d[i] = lvl_q[i-1];
        else      lvl_d[i] = lvl_q[i];
      end
    end else begin : g_mid
      always_comb begin
        if (push) lvl_d[i] = lvl_q[i-1];
        else      lvl_d[i] = lvl_q[i+1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q[i] <= '0;
      else if (lvl_en) lvl_q[i] <= lvl_d[i];
    end
  end

endmodule

// File: rtl/pseq_gate.sv
module pseq_gate
  import pseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op_class,
  input  logic       skip_set,
  output logic       exec_en,
  output logic       second_word,
  output logic [3:0] w2_kind
);

  logic       sf_q, sf_d;
  lastk_e     lk_q, lk_d;
  logic       w2_q, w2_d;
  logic       w2sq_q, w2sq_d;
  logic [3:0] w2k_q, w2k_d;
  logic       op_two;
  logic       rep_hit;

  assign op_two = is_two_word(op_class);

  always_comb begin
    rep_hit = 1'b0;
    case (op_class)
      OPC_LDAI: rep_hit = (lk_q == LK_A);
      OPC_LDLI: rep_hit = (lk_q == LK_L);
      OPC_HBIT: rep_hit = (lk_q == LK_H);
      default:  rep_hit = 1'b0;
    endcase
  end

  assign exec_en     = w2_q ? !w2sq_q : !(sf_q || rep_hit);
  assign second_word = w2_q;
  assign w2_kind     = w2k_q;

  always_comb begin
    w2_d   = 1'b0;
    w2sq_d = w2sq_q;
    w2k_d  = w2k_q;
    lk_d   = lk_q;
    sf_d   = 1'b0;
    if (w2_q) begin
      sf_d = exec_en && (w2k_q == OPC_CMPI) && skip_set;
    end else begin
      w2_d   = op_two;
      w2sq_d = !exec_en;
      w2k_d  = op_class;
      sf_d   = exec_en && !op_two && skip_set;
      if (exec_en) lk_d = load_kind(op_class);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q   <= 1'b0;
      lk_q   <= LK_NONE;
      w2_q   <= 1'b0;
      w2sq_q <= 1'b0;
      w2k_q  <= OPC_OTHER;
    end else begin
      sf_q   <= sf_d;
      lk_q   <= lk_d;
      w2_q   <= w2_d;
      w2sq_q <= w2sq_d;
      w2k_q  <= w2k_d;
    end
  end

endmodule

// File: rtl/pseq_pc.sv
module pseq_pc
  import pseq_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 6,
  localparam int PC_W  = PAGE_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_en,
  input  logic            second_word,
  input  logic [3:0]      w2_kind,
  input  logic [3:0]      op_class,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] stk_top,
  output logic [PC_W-1:0] pc,
  output logic            push,
  output logic            pop,
  output logic [PC_W-1:0] push_val
);

  logic [PC_W-1:0] pc_q, pc_d, pc_inc, pc_short;

  assign pc_inc   = pc_q + 1'b1;
  assign pc_short = {pc_q[PC_W-1:OFF_W], target[OFF_W-1:0]};
  assign push_val = pc_inc;
  assign pc       = pc_q;

  always_comb begin
    pc_d = pc_inc;
    push = 1'b0;
    pop  = 1'b0;
    if (exec_en) begin
      if (second_word) begin
        case (w2_kind)
          OPC_JMPL: pc_d = target;
          OPC_CALL: begin pc_d = target; push = 1'b1; end
          default:  pc_d = pc_inc;
        endcase
      end else begin
        case (op_class)
          OPC_JMPS: pc_d = pc_short;
          OPC_CALS: begin pc_d = pc_short; push = 1'b1; end
          OPC_RET:  begin pc_d = stk_top;  pop  = 1'b1; end
          default:  pc_d = pc_inc;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/pseq_top.sv
module pseq_top #(
  parameter int PAGE_W    = 4,
  parameter int OFF_W     = 6,
  parameter int STK_DEPTH = 2,
  localparam int PC_W     = PAGE_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op_class,
  input  logic [PC_W-1:0] target,
  input  logic            skip_set,
  output logic [PC_W-1:0] fetch_addr,
  output logic            exec_en,
  output logic            second_word
);

  logic [3:0]      w2_kind;
  logic            stk_push, stk_pop;
  logic [PC_W-1:0] stk_val, stk_top;

  pseq_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_class    (op_class),
    .skip_set    (skip_set),
    .exec_en     (exec_en),
    .second_word (second_word),
    .w2_kind     (w2_kind)
  );

  pseq_pc #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_en     (exec_en),
    .second_word (second_word),
    .w2_kind     (w2_kind),
    .op_class    (op_class),
    .target      (target),
    .stk_top     (stk_top),
    .pc          (fetch_addr),
    .push        (stk_push),
    .pop         (stk_pop),
    .push_val    (stk_val)
  );

  pseq_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (stk_push),
    .pop      (stk_pop),
    .push_val (stk_val),
    .top      (stk_top)
  );

endmodule

// File: rtl/pseq_chk.sv
module pseq_chk
  import pseq_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int OFF_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      op_class,
  input logic [PC_W-1:0] target,
  input logic            skip_set,
  input logic [PC_W-1:0] fetch_addr,
  input logic            exec_en,
  input logic            second_word,
  input logic [PC_W-1:0] stk_top
);

  // R2
  squash_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en && !second_word && !is_two_word(op_class))
      |=> fetch_addr == PC_W'($past(fetch_addr) + 1'b1));

  // R3
  short_jmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !second_word && op_class == OPC_JMPS)
      |=> fetch_addr == {$past(fetch_addr[PC_W-1:OFF_W]), $past(target[OFF_W-1:0])});

  // R4
  two_word_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!second_word && is_two_word(op_class)) |=> second_word);

  // R4
  two_word_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    second_word |=> !second_word);

  // R5
  call_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !second_word && op_class == OPC_CALS)
      |=> stk_top == PC_W'($past(fetch_addr) + 1'b1));

  // R6
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !second_word && op_class == OPC_RET)
      |=> fetch_addr == $past(stk_top));

  // R7
  skip_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !second_word && op_class == OPC_OTHER && skip_set)
      |=> !exec_en);

  // R9
  lda_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !second_word && op_class == OPC_LDAI)
      |=> (second_word || op_class != OPC_LDAI || !exec_en));

endmodule

bind pseq_top pseq_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_class    (op_class),
  .target      (target),
  .skip_set    (skip_set),
  .fetch_addr  (fetch_addr),
  .exec_en     (exec_en),
  .second_word (second_word),
  .stk_top     (stk_top)
);

// File: tb/tb_pseq_top.sv
module tb_pseq_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_class;
  logic [9:0] target;
  logic       skip_set;
  logic [9:0] fetch_addr;
  logic       exec_en;
  logic       second_word;

  always #2.5 clk = ~clk;

  // program ROM model, indexed by the fetch address
  logic [3:0] rom_op [1024];
  logic [9:0] rom_tg [1024];
  logic       rom_sk [1024];

  assign op_class = rom_op[fetch_addr];
  assign target   = rom_tg[fetch_addr];
  assign skip_set = rom_sk[fetch_addr];

  pseq_top dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_class    (op_class),
    .target      (target),
    .skip_set    (skip_set),
    .fetch_addr  (fetch_addr),
    .exec_en     (exec_en),
    .second_word (second_word)
  );

  typedef struct {
    logic [9:0] a;
    logic       ex;
    logic       w2;
    string      rq;
  } exp_t;

  exp_t q[$];
  exp_t it;
  int   n_chk = 0;
  int   n_bad = 0;
  logic armed = 1'b0;

  task automatic clear_rom();
    for (int i = 0; i < 1024; i++) begin
      rom_op[i] = 4'd0;
      rom_tg[i] = '0;
      rom_sk[i] = 1'b0;
    end
  endtask

  task automatic put(input int a, input logic [3:0] op, input int tg, input logic sk);
    rom_op[a] = op;
    rom_tg[a] = 10'(tg);
    rom_sk[a] = sk;
  endtask

  task automatic expect_at(input int a, input logic ex, input logic w2, input string rq);
    exp_t e;
    e.a  = 10'(a);
    e.ex = ex;
    e.w2 = w2;
    e.rq = rq;
    q.push_back(e);
  endtask

  task automatic run_seq();
    @(posedge clk);
    #1 rst_n = 1'b1;
    armed = 1'b1;
    wait (q.size() == 0);
    @(posedge clk);
    #1 armed = 1'b0;
    rst_n = 1'b0;
  endtask

  // monitor: one scoreboard entry per cycle, sampled on the falling edge
  always @(negedge clk) begin
    if (armed && q.size() > 0) begin
      it = q.pop_front();
      n_chk++;
      if (fetch_addr !== it.a || exec_en !== it.ex || second_word !== it.w2) begin
        n_bad++;
        $display("FAIL %s: addr/exec/w2 actual=%03h/%0b/%0b expected=%03h/%0b/%0b",
                 it.rq, fetch_addr, exec_en, second_word, it.a, it.ex, it.w2);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clear_rom();
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (fetch_addr !== 10'h000 || second_word !== 1'b0 || exec_en !== 1'b1) begin
      n_bad++;
      $display("FAIL R1: in reset addr/exec/w2 actual=%03h/%0b/%0b expected=000/1/0",
               fetch_addr, exec_en, second_word);
    end

    // R2, R3: short jumps stay on page, increment crosses pages
    clear_rom();
    put(10'h001, 4'd1, 10'h03E, 1'b0);
    put(10'h040, 4'd1, 10'h005, 1'b0);
    expect_at(10'h000, 1, 0, "R1");
    expect_at(10'h001, 1, 0, "R3");
    expect_at(10'h03E, 1, 0, "R3");
    expect_at(10'h03F, 1, 0, "R2");
    expect_at(10'h040, 1, 0, "R2");
    expect_at(10'h045, 1, 0, "R3");
    run_seq();

    // R4, R2: long jump and wrap at the top of the space
    clear_rom();
    put(10'h000, 4'd3, 0, 1'b0);
    put(10'h001, 4'd0, 10'h3FE, 1'b0);
    expect_at(10'h000, 1, 0, "R4");
    expect_at(10'h001, 1, 1, "R4");
    expect_at(10'h3FE, 1, 0, "R4");
    expect_at(10'h3FF, 1, 0, "R2");
    expect_at(10'h000, 1, 0, "R2");
    run_seq();

    // R5, R6: three nested calls, three returns, oldest entry lost
    clear_rom();
    put(10'h000, 4'd2, 10'h010, 1'b0);
    put(10'h010, 4'd4, 0, 1'b0);
    put(10'h011, 4'd0, 10'h200, 1'b0);
    put(10'h200, 4'd2, 10'h008, 1'b0);
    put(10'h208, 4'd5, 0, 1'b0);
    put(10'h201, 4'd5, 0, 1'b0);
    put(10'h012, 4'd5, 0, 1'b0);
    expect_at(10'h000, 1, 0, "R5");
    expect_at(10'h010, 1, 0, "R5");
    expect_at(10'h011, 1, 1, "R5");
    expect_at(10'h200, 1, 0, "R5");
    expect_at(10'h208, 1, 0, "R5");
    expect_at(10'h201, 1, 0, "R6");
    expect_at(10'h012, 1, 0, "R6");
    expect_at(10'h012, 1, 0, "R6");
    expect_at(10'h012, 1, 0, "R6");
    run_seq();

    // R7, R8, R4: skip flag, squashed branch, compare-immediate, squashed long jump
    clear_rom();
    put(10'h000, 4'd0, 0, 1'b1);
    put(10'h001, 4'd1, 10'h030, 1'b1);
    put(10'h003, 4'd9, 0, 1'b0);
    put(10'h004, 4'd0, 0, 1'b1);
    put(10'h005, 4'd3, 0, 1'b0);
    put(10'h006, 4'd0, 10'h100, 1'b0);
    put(10'h007, 4'd9, 0, 1'b0);
    expect_at(10'h000, 1, 0, "R7");
    expect_at(10'h001, 0, 0, "R7");
    expect_at(10'h002, 1, 0, "R8");
    expect_at(10'h003, 1, 0, "R4");
    expect_at(10'h004, 1, 1, "R7");
    expect_at(10'h005, 0, 0, "R8");
    expect_at(10'h006, 0, 1, "R8");
    expect_at(10'h007, 1, 0, "R8");
    expect_at(10'h008, 1, 1, "R4");
    expect_at(10'h009, 1, 0, "R7");
    run_seq();

    // R9 to R12: repeated immediate loads and page-bit operations
    clear_rom();
    put(0,  4'd6, 0, 1'b0);
    put(1,  4'd6, 0, 1'b0);
    put(2,  4'd6, 0, 1'b1);
    put(3,  4'd7, 0, 1'b0);
    put(4,  4'd7, 0, 1'b0);
    put(5,  4'd8, 0, 1'b0);
    put(6,  4'd8, 0, 1'b0);
    put(7,  4'd6, 0, 1'b0);
    put(8,  4'd0, 0, 1'b1);
    put(9,  4'd6, 0, 1'b0);
    put(10, 4'd6, 0, 1'b0);
    put(11, 4'd6, 0, 1'b0);
    expect_at(0,  1, 0, "R9");
    expect_at(1,  0, 0, "R9");
    expect_at(2,  0, 0, "R9");
    expect_at(3,  1, 0, "R10");
    expect_at(4,  0, 0, "R10");
    expect_at(5,  1, 0, "R11");
    expect_at(6,  0, 0, "R11");
    expect_at(7,  1, 0, "R11");
    expect_at(8,  1, 0, "R12");
    expect_at(9,  0, 0, "R12");
    expect_at(10, 1, 0, "R12");
    expect_at(11, 0, 0, "R9");
    expect_at(12, 1, 0, "R9");
    run_seq();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule